// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode Unit

This unit reads the instruction stream of a 16-bit register machine one byte per clock from a synchronous, byte-wide memory port. An instruction takes 1 to 4 bytes, and its length follows from the range its opcode byte falls in. After a start pulse the unit requests addresses in strict sequence. It collects the opcode, one or two register bytes and a big-endian 16-bit immediate. When the last byte of an instruction arrives it presents the decoded fields for one cycle: operation class, operation index, register indices, immediate, the instruction's own address, the address that follows it, and a jump target formed from a code base.

The unit checks each opcode against the legal ranges. It also checks every register byte that an instruction actually uses and rejects any value above 0x0F. An illegal opcode, a bad register code or the program-end opcode stops the unit, and it stays idle until the next start pulse. A start pulse given while an instruction is half read discards that instruction and begins again at the new address. Executing instructions, testing flags and translating addresses are left to the neighbouring blocks.

Top module: `insn_fetch_decoder`

## Requirements
- R1: While and after reset, until the first start pulse, `busy`, `mem_rd` and `dec_valid` are 0.
- R2: A start pulse sampled at a clock edge puts `start_pc` on `mem_addr` with `mem_rd` high from that edge on. While busy, the address rises by one every cycle. The memory returns the addressed byte on `mem_rdata` at the next edge.
- R3: Opcodes 0x16–0x1C take 3 bytes. Opcodes 0x30–0x3D, 0x51 and 0x52 take 4 bytes. Opcodes 0x71–0x78 take 2 bytes and 0xF1–0xF3 take 1. `dec_valid` is a one-cycle pulse in the cycle after the edge at which the instruction's last byte is accepted. For the first instruction after a start, that is N+1 edges after the start edge, where N is the length. Each following instruction pulses exactly its own length in cycles after the previous pulse.
- R4: `dec_class` encodes 0 for register-register (0x16–0x1C) and 1 for register-immediate (0x30–0x36, plus the service call 0x3D). It encodes 2 for branch, jump and call (0x37–0x3C), 3 for memory (0x51–0x52), 4 for single-operand (0x71–0x78), 5 for no-operand (0xF1–0xF3) and 7 for an illegal opcode. `dec_op` is the opcode minus the lowest opcode of its group. The exception is 0x3D, whose `dec_op` is 7. For branches, `dec_op` values 0 to 3 mean zero, not-zero, carry and sign, 4 means jump and 5 means call.
- R5: `dec_ra` is the low 4 bits of the first register byte for classes 0, 1, 3 and 4, and 0 for the other classes. `dec_rb` is the low 4 bits of the second register byte for class 0, and 0 otherwise.
- R6: For 4-byte instructions, `dec_imm` is the third byte in bits 15:8 and the fourth byte in bits 7:0. For all other instructions it is 0.
- R7: `dec_pc` is the address of the opcode byte. `dec_next_pc` is `dec_pc` plus the instruction length, modulo 2^ADDR_W. The next instruction is read from `dec_next_pc`.
- R8: `dec_target` equals `code_base` plus `dec_imm`, modulo 2^ADDR_W.
- R9: An opcode outside the listed ranges pulses `dec_valid` with `err_opcode` = 1 in the cycle after that byte is accepted. `busy` and `mem_rd` fall at that same edge. At most one of `dec_end`, `err_opcode` and `err_reg` is set.
- R10: A register byte above 0x0F in a checked position (class 0, 1, 3 or 4) pulses `dec_valid` with `err_reg` = 1 in the cycle after that byte is accepted, and the unit stops. The register byte of branch, jump and call instructions may hold any value without error.
- R11: Opcode 0xF3 pulses `dec_valid` with `dec_end` = 1 and stops the unit. 0xF1 and 0xF2 do not stop it. After a stop, no further `dec_valid` pulse or memory read occurs until the next start.
- R12: A start pulse while busy abandons any partly read instruction. The next pulse belongs to the instruction at the new `start_pc`, with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin fetching at `start_pc` |
| start_pc | input | ADDR_W | Address of the first opcode |
| code_base | input | ADDR_W | Base added to immediates for jump targets |
| mem_addr | output | ADDR_W | Byte address requested from memory |
| mem_rd | output | 1 | Read request for `mem_addr` |
| mem_rdata | input | 8 | Byte returned one cycle after the request |
| busy | output | 1 | Unit is fetching |
| dec_valid | output | 1 | Decoded fields valid this cycle |
| dec_class | output | 3 | Operation class |
| dec_op | output | 4 | Operation index within the class |
| dec_ra | output | REG_W | First register index |
| dec_rb | output | REG_W | Second register index |
| dec_imm | output | 16 | Immediate value |
| dec_pc | output | ADDR_W | Address of this instruction |
| dec_next_pc | output | ADDR_W | Address of the following instruction |
| dec_target | output | ADDR_W | `code_base` plus immediate |
| dec_end | output | 1 | Program-end instruction decoded |
| err_opcode | output | 1 | Illegal opcode |
| err_reg | output | 1 | Illegal register code |

## Verification
The bench builds the unit with ADDR_W = 10 and REG_W = 4. A 1 KiB memory model then covers the whole address space, and each of the 256 opcode values can sit at its own word-aligned address, so one sweep checks every opcode's length, class, fields, latency and stop behaviour. Both register byte positions of a register-register instruction are swept over all 256 byte values. The other classes are probed at the 0x0F/0x10 edge, including branches whose register byte is ignored. A back-to-back stream checks the spacing of pulses and the halt after the end instruction, and a restart in mid-instruction checks that the partial state is discarded.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  localparam int BYTE_W = 8;
  localparam int IMM_W  = 16;
  localparam int NGRP   = 7;

  typedef enum logic [2:0] {
    CLS_RR   = 3'd0,
    CLS_RI   = 3'd1,
    CLS_BR   = 3'd2,
    CLS_MEM  = 3'd3,
    CLS_ONE  = 3'd4,
    CLS_NONE = 3'd5,
    CLS_RSV  = 3'd6,
    CLS_BAD  = 3'd7
  } icls_e;

  typedef struct packed {
    logic       legal;
    icls_e      cls;
    logic       chk;
    logic [2:0] len;
    logic [3:0] sub;
  } opinfo_t;

  localparam logic [BYTE_W-1:0] OP_END = 8'hF3;

  // Opcode groups, group 0 in the least significant slice.
  // 0 reg-reg, 1 reg-imm ALU, 2 branch/jump/call, 3 service call,
  // 4 memory, 5 single operand, 6 no operand.
  localparam logic [NGRP*8-1:0] GRP_LO  = {8'hF1, 8'h71, 8'h51, 8'h3D, 8'h37, 8'h30, 8'h16};
  localparam logic [NGRP*8-1:0] GRP_HI  = {8'hF3, 8'h78, 8'h52, 8'h3D, 8'h3C, 8'h36, 8'h1C};
  localparam logic [NGRP*3-1:0] GRP_LEN = {3'd1, 3'd2, 3'd4, 3'd4, 3'd4, 3'd4, 3'd3};
  localparam logic [NGRP*3-1:0] GRP_CLS = {3'd5, 3'd4, 3'd3, 3'd1, 3'd2, 3'd1, 3'd0};
  localparam logic [NGRP-1:0]   GRP_CHK = 7'b0111011;
  localparam logic [NGRP*4-1:0] GRP_SUB = {4'd0, 4'd0, 4'd0, 4'd7, 4'd0, 4'd0, 4'd0};

endpackage

// File: rtl/ifd_fetch.sv
module ifd_fetch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_pc,
  input  logic              halt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              byte_vld,
  output logic              running
);

  logic [ADDR_W-1:0] addr_q;
  logic              run_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      run_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else if (restart) begin
      addr_q <= restart_pc;
      run_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else if (halt) begin
      run_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= run_q;
      if (run_q) addr_q <= addr_q + 1'b1;
    end
  end

  assign mem_addr = addr_q;
  assign mem_rd   = run_q;
  assign byte_vld = vld_q;
  assign running  = run_q;

  // R2: addresses advance by one per cycle while fetching
  a_r2_seq_addr: assert property (@(posedge clk) disable iff (rst)
    (run_q && !restart && !halt) |=> (mem_addr == $past(mem_addr) + 1'b1));

  // R2: a byte is only delivered for an address that was requested
  a_r2_idle_no_byte: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !byte_vld);

endmodule

// File: rtl/ifd_opclass.sv
module ifd_opclass
  import ifd_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output opinfo_t           info
);

  logic [NGRP-1:0] hit;
  logic [3:0]      gsub [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [BYTE_W-1:0] diff;
    assign hit[g]  = (opcode >= GRP_LO[g*8 +: 8]) && (opcode <= GRP_HI[g*8 +: 8]);
    assign diff    = opcode - GRP_LO[g*8 +: 8];
    assign gsub[g] = GRP_SUB[g*4 +: 4] + diff[3:0];
  end

  always_comb begin
    info       = '0;
    info.cls   = CLS_BAD;
    for (int g = 0; g < NGRP; g++) begin
      if (hit[g]) begin
        info.legal = 1'b1;
        info.cls   = icls_e'(GRP_CLS[g*3 +: 3]);
        info.chk   = GRP_CHK[g];
        info.len   = GRP_LEN[g*3 +: 3];
        info.sub   = gsub[g];
      end
    end
  end

endmodule

// File: rtl/ifd_assemble.sv
module ifd_assemble
  import ifd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_pc,
  input  logic [ADDR_W-1:0] code_base,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  opinfo_t           info_in,
  output logic              halt,
  output logic              dec_valid,
  output logic [2:0]        dec_class,
  output logic [3:0]        dec_op,
  output logic [REG_W-1:0]  dec_ra,
  output logic [REG_W-1:0]  dec_rb,
  output logic [IMM_W-1:0]  dec_imm,
  output logic [ADDR_W-1:0] dec_pc,
  output logic [ADDR_W-1:0] dec_next_pc,
  output logic [ADDR_W-1:0] dec_target,
  output logic              dec_end,
  output logic              err_opcode,
  output logic              err_reg
);

  localparam int NUM_REGS = 1 << REG_W;

  logic [1:0]        idx_q;
  opinfo_t           info_q;
  logic [BYTE_W-1:0] imm_hi_q;
  logic [REG_W-1:0]  ra_q;
  logic [ADDR_W-1:0] pc_q;

  opinfo_t           cur;
  logic              reg_bad;
  logic              emit, e_op, e_reg, is_end;
  logic [REG_W-1:0]  ra_n, rb_n;
  logic [IMM_W-1:0]  imm_n;

  always_comb begin
    cur     = (idx_q == 2'd0) ? info_in : info_q;
    reg_bad = (byte_in >= BYTE_W'(NUM_REGS));
    emit    = 1'b0;
    e_op    = 1'b0;
    e_reg   = 1'b0;
    is_end  = 1'b0;
    if (byte_vld) begin
      case (idx_q)
        2'd0: begin
          if (!info_in.legal) begin
            emit = 1'b1;
            e_op = 1'b1;
          end else if (info_in.len == 3'd1) begin
            emit   = 1'b1;
            is_end = (byte_in == OP_END);
          end
        end
        2'd1: begin
          if (info_q.chk && reg_bad) begin
            emit  = 1'b1;
            e_reg = 1'b1;
          end else if (info_q.len == 3'd2) begin
            emit = 1'b1;
          end
        end
        2'd2: begin
          if (info_q.cls == CLS_RR) begin
            emit  = 1'b1;
            e_reg = reg_bad;
          end
        end
        default: emit = 1'b1;
      endcase
    end
    halt = emit && (e_op || e_reg || is_end);

    case (idx_q)
      2'd0:    ra_n = '0;
      2'd1:    ra_n = info_q.chk ? byte_in[REG_W-1:0] : '0;
      default: ra_n = ra_q;
    endcase
    rb_n  = (idx_q == 2'd2 && info_q.cls == CLS_RR) ? byte_in[REG_W-1:0] : '0;
    imm_n = (idx_q == 2'd3) ? {imm_hi_q, byte_in} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      info_q      <= '0;
      imm_hi_q    <= '0;
      ra_q        <= '0;
      pc_q        <= '0;
      dec_valid   <= 1'b0;
      dec_class   <= '0;
      dec_op      <= '0;
      dec_ra      <= '0;
      dec_rb      <= '0;
      dec_imm     <= '0;
      dec_pc      <= '0;
      dec_next_pc <= '0;
      dec_target  <= '0;
      dec_end     <= 1'b0;
      err_opcode  <= 1'b0;
      err_reg     <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (restart) begin
        idx_q <= '0;
        pc_q  <= restart_pc;
      end else if (byte_vld) begin
        if (idx_q == 2'd0) info_q   <= info_in;
        if (idx_q == 2'd1) ra_q     <= ra_n;
        if (idx_q == 2'd2) imm_hi_q <= byte_in;
        if (emit) begin
          idx_q       <= '0;
          pc_q        <= pc_q + ADDR_W'(cur.len);
          dec_valid   <= 1'b1;
          dec_class   <= cur.cls;
          dec_op      <= cur.sub;
          dec_ra      <= ra_n;
          dec_rb      <= rb_n;
          dec_imm     <= imm_n;
          dec_pc      <= pc_q;
          dec_next_pc <= pc_q + ADDR_W'(cur.len);
          dec_target  <= code_base + ADDR_W'(imm_n);
          dec_end     <= is_end;
          err_opcode  <= e_op;
          err_reg     <= e_reg;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R9: at most one terminating condition per decoded instruction
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $onehot0({dec_end, err_opcode, err_reg}));

  // R9: operand bytes are only collected behind a legal opcode
  a_r9_partial_legal: assert property (@(posedge clk) disable iff (rst)
    (idx_q != 2'd0) |-> (info_q.legal && (3'(idx_q) < info_q.len)));

  // R5: second register index only for register-register class
  a_r5_rb_only_rr: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_class != 3'(CLS_RR)) |-> (dec_rb == '0));

endmodule

// File: rtl/insn_fetch_decoder.sv
module insn_fetch_decoder
  import ifd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [ADDR_W-1:0] code_base,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              dec_valid,
  output logic [2:0]        dec_class,
  output logic [3:0]        dec_op,
  output logic [REG_W-1:0]  dec_ra,
  output logic [REG_W-1:0]  dec_rb,
  output logic [15:0]       dec_imm,
  output logic [ADDR_W-1:0] dec_pc,
  output logic [ADDR_W-1:0] dec_next_pc,
  output logic [ADDR_W-1:0] dec_target,
  output logic              dec_end,
  output logic              err_opcode,
  output logic              err_reg
);

  logic    halt;
  logic    byte_vld;
  opinfo_t info;

  ifd_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .restart    (start),
    .restart_pc (start_pc),
    .halt       (halt),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .byte_vld   (byte_vld),
    .running    (busy)
  );

  ifd_opclass u_class (
    .opcode (mem_rdata),
    .info   (info)
  );

  ifd_assemble #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_asm (
    .clk         (clk),
    .rst         (rst),
    .restart     (start),
    .restart_pc  (start_pc),
    .code_base   (code_base),
    .byte_vld    (byte_vld),
    .byte_in     (mem_rdata),
    .info_in     (info),
    .halt        (halt),
    .dec_valid   (dec_valid),
    .dec_class   (dec_class),
    .dec_op      (dec_op),
    .dec_ra      (dec_ra),
    .dec_rb      (dec_rb),
    .dec_imm     (dec_imm),
    .dec_pc      (dec_pc),
    .dec_next_pc (dec_next_pc),
    .dec_target  (dec_target),
    .dec_end     (dec_end),
    .err_opcode  (err_opcode),
    .err_reg     (err_reg)
  );

  // R11: a terminating decode coincides with the fetcher having stopped
  a_r11_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && (dec_end || err_opcode || err_reg)) |-> (!busy && !mem_rd));

endmodule

// File: tb/test_insn_fetch_decoder.sv
module test_insn_fetch_decoder;

  localparam int AW   = 10;
  localparam int RW   = 4;
  localparam int MSZ  = 1 << AW;
  localparam int CB   = 'h155;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_pc = '0;
  logic [AW-1:0] code_base = AW'(CB);
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [7:0]    mem_rdata = '0;
  logic          busy, dec_valid, dec_end, err_opcode, err_reg;
  logic [2:0]    dec_class;
  logic [3:0]    dec_op;
  logic [RW-1:0] dec_ra, dec_rb;
  logic [15:0]   dec_imm;
  logic [AW-1:0] dec_pc, dec_next_pc, dec_target;

  logic [7:0] mem [MSZ];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  insn_fetch_decoder #(.ADDR_W(AW), .REG_W(RW)) i_insn_fetch_decoder (
    .clk(clk), .rst(rst), .start(start), .start_pc(start_pc), .code_base(code_base),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .busy(busy),
    .dec_valid(dec_valid), .dec_class(dec_class), .dec_op(dec_op), .dec_ra(dec_ra),
    .dec_rb(dec_rb), .dec_imm(dec_imm), .dec_pc(dec_pc), .dec_next_pc(dec_next_pc),
    .dec_target(dec_target), .dec_end(dec_end), .err_opcode(err_opcode), .err_reg(err_reg)
  );

  task automatic chkv(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected model from the requirement text
  function automatic int e_len(input int op);
    if (op >= 'h16 && op <= 'h1C) return 3;
    if (op >= 'h30 && op <= 'h3D) return 4;
    if (op == 'h51 || op == 'h52) return 4;
    if (op >= 'h71 && op <= 'h78) return 2;
    if (op >= 'hF1 && op <= 'hF3) return 1;
    return 0;
  endfunction

  function automatic int e_cls(input int op);
    if (op >= 'h16 && op <= 'h1C) return 0;
    if ((op >= 'h30 && op <= 'h36) || op == 'h3D) return 1;
    if (op >= 'h37 && op <= 'h3C) return 2;
    if (op == 'h51 || op == 'h52) return 3;
    if (op >= 'h71 && op <= 'h78) return 4;
    if (op >= 'hF1 && op <= 'hF3) return 5;
    return 7;
  endfunction

  function automatic int e_sub(input int op);
    case (e_cls(op))
      0: return op - 'h16;
      1: return (op == 'h3D) ? 7 : op - 'h30;
      2: return op - 'h37;
      3: return op - 'h51;
      4: return op - 'h71;
      5: return op - 'hF1;
      default: return 0;
    endcase
  endfunction

  function automatic bit e_chk(input int c);
    return (c == 0 || c == 1 || c == 3 || c == 4);
  endfunction

  task automatic kick(input int pc);
    @(negedge clk);
    start_pc = AW'(pc);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_first(output int cnt);
    cnt = 1;
    while (!dec_valid && cnt < 60) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic wait_next(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!dec_valid && cnt < 60);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    for (int a = 0; a < MSZ; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chkv("R1 busy", int'(busy), 0);
    chkv("R1 mem_rd", int'(mem_rd), 0);
    chkv("R1 dec_valid", int'(dec_valid), 0);

    // opcode sweep: every byte value as an opcode at its own address
    for (int op = 0; op < 256; op++) begin
      int pc, len, cls, imm;
      bit bad;
      pc = op * 4;
      mem[pc] = 8'(op); mem[pc+1] = 8'h05; mem[pc+2] = 8'h0A; mem[pc+3] = 8'hC3;
      kick(pc);
      wait_first(cnt);
      len = e_len(op);
      bad = (len == 0);
      cls = e_cls(op);
      imm = (len == 4) ? 'h0AC3 : 0;
      chkv($sformatf("R3 latency op=%0h", op), cnt, bad ? 3 : len + 2);
      chkv($sformatf("R4 class op=%0h", op), int'(dec_class), cls);
      chkv($sformatf("R9 err_opcode op=%0h", op), int'(err_opcode), int'(bad));
      chkv($sformatf("R11 end op=%0h", op), int'(dec_end), int'(op == 'hF3));
      chkv($sformatf("R11 busy op=%0h", op), int'(busy), int'(!(bad || op == 'hF3)));
      chkv($sformatf("R7 pc op=%0h", op), int'(dec_pc), pc);
      if (!bad) begin
        chkv($sformatf("R4 op op=%0h", op), int'(dec_op), e_sub(op));
        chkv($sformatf("R5 ra op=%0h", op), int'(dec_ra), e_chk(cls) ? 5 : 0);
        chkv($sformatf("R5 rb op=%0h", op), int'(dec_rb), (cls == 0) ? 'hA : 0);
        chkv($sformatf("R6 imm op=%0h", op), int'(dec_imm), imm);
        chkv($sformatf("R7 next op=%0h", op), int'(dec_next_pc), (pc + len) % MSZ);
        chkv($sformatf("R8 target op=%0h", op), int'(dec_target), (CB + imm) % MSZ);
        chkv($sformatf("R10 no err_reg op=%0h", op), int'(err_reg), 0);
      end
    end

    // register byte sweeps on a register-register instruction
    for (int v = 0; v < 256; v++) begin
      mem['h40] = 8'h17; mem['h41] = 8'(v); mem['h42] = 8'h03; mem['h43] = 8'hF3;
      kick('h40);
      wait_first(cnt);
      chkv($sformatf("R10 rr reg1 err v=%0h", v), int'(err_reg), int'(v > 15));
      chkv($sformatf("R10 rr reg1 latency v=%0h", v), cnt, (v > 15) ? 4 : 5);
      if (v <= 15) chkv($sformatf("R5 rr ra v=%0h", v), int'(dec_ra), v);
      mem['h41] = 8'h02; mem['h42] = 8'(v);
      kick('h40);
      wait_first(cnt);
      chkv($sformatf("R10 rr reg2 err v=%0h", v), int'(err_reg), int'(v > 15));
      chkv($sformatf("R10 rr reg2 latency v=%0h", v), cnt, 5);
      if (v <= 15) chkv($sformatf("R5 rr rb v=%0h", v), int'(dec_rb), v);
    end

    // checked register positions in other classes
    for (int k = 0; k < 4; k++) begin
      int op;
      op = (k == 0) ? 'h31 : (k == 1) ? 'h3D : (k == 2) ? 'h51 : 'h75;
      for (int j = 0; j < 3; j++) begin
        int v;
        v = (j == 0) ? 'h0F : (j == 1) ? 'h10 : 'hFF;
        mem['h80] = 8'(op); mem['h81] = 8'(v); mem['h82] = 8'h00; mem['h83] = 8'h01;
        kick('h80);
        wait_first(cnt);
        chkv($sformatf("R10 err op=%0h v=%0h", op, v), int'(err_reg), int'(v > 15));
        chkv($sformatf("R10 latency op=%0h v=%0h", op, v), cnt, (v > 15) ? 4 : e_len(op) + 2);
        chkv($sformatf("R10 busy op=%0h v=%0h", op, v), int'(busy), int'(v <= 15));
      end
    end

    // branch, jump and call ignore their register byte
    for (int op = 'h37; op <= 'h3C; op++) begin
      for (int j = 0; j < 3; j++) begin
        int v;
        v = (j == 0) ? 'h10 : (j == 1) ? 'hFF : 'h07;
        mem['hA0] = 8'(op); mem['hA1] = 8'(v); mem['hA2] = 8'h01; mem['hA3] = 8'h10;
        kick('hA0);
        wait_first(cnt);
        chkv($sformatf("R10 branch no err op=%0h v=%0h", op, v), int'(err_reg), 0);
        chkv($sformatf("R5 branch ra op=%0h v=%0h", op, v), int'(dec_ra), 0);
        chkv($sformatf("R8 branch target op=%0h", op), int'(dec_target), (CB + 'h0110) % MSZ);
      end
    end

    // back-to-back stream ending in END
    begin
      int bytes [16] = '{'h30,'h01,'h12,'h34, 'h17,'h01,'h02, 'h75,'h03, 'hF2,
                         'h52,'h04,'h00,'h10, 'hF3, 'h00};
      int lens [6] = '{4, 3, 2, 1, 4, 1};
      int clss [6] = '{1, 0, 4, 5, 3, 5};
      int subs [6] = '{0, 1, 4, 1, 1, 2};
      int imms [6] = '{'h1234, 0, 0, 0, 'h0010, 0};
      int pc;
      for (int b = 0; b < 16; b++) mem['h300 + b] = 8'(bytes[b]);
      kick('h300);
      chkv("R2 first addr", int'(mem_addr), 'h300);
      chkv("R2 mem_rd", int'(mem_rd), 1);
      @(negedge clk);
      chkv("R2 second addr", int'(mem_addr), 'h301);
      cnt = 2;
      while (!dec_valid && cnt < 60) begin
        @(negedge clk);
        cnt++;
      end
      pc = 'h300;
      for (int i = 0; i < 6; i++) begin
        if (i > 0) wait_next(cnt);
        chkv($sformatf("R3 stream spacing i=%0d", i), cnt, (i == 0) ? lens[i] + 2 : lens[i]);
        chkv($sformatf("R7 stream pc i=%0d", i), int'(dec_pc), pc);
        chkv($sformatf("R4 stream class i=%0d", i), int'(dec_class), clss[i]);
        chkv($sformatf("R4 stream op i=%0d", i), int'(dec_op), subs[i]);
        chkv($sformatf("R6 stream imm i=%0d", i), int'(dec_imm), imms[i]);
        pc = pc + lens[i];
      end
      chkv("R11 stream end", int'(dec_end), 1);
      chkv("R11 stream busy", int'(busy), 0);
      cnt = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (dec_valid || mem_rd) cnt++;
      end
      chkv("R11 quiet after end", cnt, 0);
    end

    // restart in the middle of an instruction
    mem['h200] = 8'h51; mem['h201] = 8'h01; mem['h202] = 8'h00; mem['h203] = 8'h20;
    mem['h210] = 8'hF2; mem['h211] = 8'hF3;
    kick('h200);
    @(negedge clk);
    @(negedge clk);
    kick('h210);
    wait_first(cnt);
    chkv("R12 restart latency", cnt, 3);
    chkv("R12 restart pc", int'(dec_pc), 'h210);
    chkv("R12 restart class", int'(dec_class), 5);
    chkv("R12 restart op", int'(dec_op), 1);
    wait_next(cnt);
    chkv("R12 restart second", cnt, 1);
    chkv("R11 restart end", int'(dec_end), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule